// File: doc/BRIEF.md
# KCS Host Interrupt Combiner

This block drives the one level-sensitive interrupt line that a keyboard-controller-style host interface presents to the host. Two sources share the line. The first is an output-buffer-full event, raised when the controller places a byte for the host. The second is an attention request, raised when the controller has something for system software. Each source keeps its own pending flag, and each flag is cleared by a different host access. A read of the data register clears the buffer-full source. A read of the status register clears the attention source.

The line is raised only when a source becomes pending for the first time while the other source is idle. Raising also needs both the interface configuration to use interrupts and the run-time enable to be set. Lowering happens when a source is cleared while the other source is idle, and lowering is never gated by the configuration or the enable. The line is a register, so changing the enable alone never moves it. The block also returns the attention status bit, which the transfer logic places in its status register.

Top module: `kcs_irq_combiner`

## Requirements
- R1: A buffer-full set pulse (`obf_set_i`=1) on an idle buffer-full source makes that source pending. It raises `irq_o` on the next edge if the attention source is not pending and interrupts are allowed.
- R2: A data-register read (`rd_data_i`=1) clears the buffer-full source. It lowers `irq_o` if the attention source is not pending, and otherwise leaves the line as it is.
- R3: A status-register read (`rd_stat_i`=1) clears the attention source. It lowers `irq_o` if the buffer-full source is not pending. It does not change `atn_stat_o`.
- R4: An attention set (`atn_set_i`=1) always sets `atn_stat_o`. If `atn_irq_req_i`=1 and attention is not yet pending, it also makes attention pending and raises `irq_o` when buffer-full is not pending and interrupts are allowed. With `atn_irq_req_i`=0 only `atn_stat_o` changes.
- R5: An attention clear (`atn_clr_i`=1) clears `atn_stat_o` and the attention pending flag. It lowers `irq_o` if the buffer-full source is not pending.
- R6: Interrupts are allowed only when `use_irq_i`=1 and `irq_en_i`=1. A raise attempted while they are not allowed still marks the source pending but leaves the line low. Lowering ignores both inputs.
- R7: `irq_o` is registered and changes only on the raise and lower events of R1 to R5. A change of `use_irq_i` or `irq_en_i` by itself never moves it.
- R8: Events in one cycle take effect in this order: the attention update, then the buffer-full set, then the data read, then the status read. If `atn_set_i` and `atn_clr_i` are both high, the clear wins.
- R9: Reset (`rst_n`=0) clears both pending flags and `atn_stat_o` and drives `irq_o` inactive.
- R10: Setting a source that is already pending does nothing. In particular, it does not raise a line that stayed low because the source was set while interrupts were not allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| obf_set_i | input | 1 | Pulse: output buffer became full |
| atn_set_i | input | 1 | Pulse: set the attention status bit |
| atn_clr_i | input | 1 | Pulse: clear the attention status bit |
| atn_irq_req_i | input | 1 | Qualifies `atn_set_i`: also request an interrupt |
| rd_data_i | input | 1 | Pulse: host read of the data register |
| rd_stat_i | input | 1 | Pulse: host read of the status register |
| use_irq_i | input | 1 | Configuration: the interface uses an interrupt |
| irq_en_i | input | 1 | Run-time interrupt enable |
| irq_o | output | 1 | Level interrupt line to the host |
| atn_stat_o | output | 1 | Attention status bit |

## Verification
The bench builds the block with its default active-high polarity, `ACTIVE_LOW`=0, so the pending logic can be compared directly with the expected line level. The vector walk runs the two sources overlapping, with clears in both orders. It attempts raises while disabled and then enables without any event. It applies coincident events to pin down the same-cycle ordering and the clear-over-set rule. A mid-run reset, followed by a fresh raise, shows that no pending state survives reset.

// File: rtl/kcs_irq_combiner.sv
module kcs_irq_combiner #(
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic obf_set_i,
  input  logic atn_set_i,
  input  logic atn_clr_i,
  input  logic atn_irq_req_i,
  input  logic rd_data_i,
  input  logic rd_stat_i,
  input  logic use_irq_i,
  input  logic irq_en_i,
  output logic irq_o,
  output logic atn_stat_o
);

  logic obf_pend_q, atn_pend_q, line_q, stat_q;
  logic obf_pend_d, atn_pend_d, line_d, stat_d;
  logic allow;

  assign allow = use_irq_i & irq_en_i;

  always_comb begin
    obf_pend_d = obf_pend_q;
    atn_pend_d = atn_pend_q;
    line_d     = line_q;
    stat_d     = stat_q;

    if (atn_clr_i) begin
      stat_d = 1'b0;
      if (atn_pend_d) begin
        atn_pend_d = 1'b0;
        if (!obf_pend_d) line_d = 1'b0;
      end
    end else if (atn_set_i) begin
      stat_d = 1'b1;
      if (atn_irq_req_i && !atn_pend_d) begin
        atn_pend_d = 1'b1;
        if (!obf_pend_d && allow) line_d = 1'b1;
      end
    end

    if (obf_set_i && !obf_pend_d) begin
      obf_pend_d = 1'b1;
      if (!atn_pend_d && allow) line_d = 1'b1;
    end

    if (rd_data_i && obf_pend_d) begin
      obf_pend_d = 1'b0;
      if (!atn_pend_d) line_d = 1'b0;
    end

    if (rd_stat_i && atn_pend_d) begin
      atn_pend_d = 1'b0;
      if (!obf_pend_d) line_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      obf_pend_q <= 1'b0;
      atn_pend_q <= 1'b0;
      line_q     <= 1'b0;
      stat_q     <= 1'b0;
    end else begin
      obf_pend_q <= obf_pend_d;
      atn_pend_q <= atn_pend_d;
      line_q     <= line_d;
      stat_q     <= stat_d;
    end
  end

  assign irq_o      = line_q ^ ACTIVE_LOW;
  assign atn_stat_o = stat_q;

  AST_LINE_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    line_q |-> (obf_pend_q || atn_pend_q)); // R7
  AST_NO_RAISE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (line_q && !$past(line_q)) |-> $past(use_irq_i && irq_en_i)); // R6
  AST_DATA_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_i |=> !obf_pend_q); // R2
  AST_STAT_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat_i |=> !atn_pend_q); // R3
  AST_ATN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    atn_clr_i |=> (!atn_pend_q && !stat_q)); // R5
  AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(obf_set_i || atn_set_i || atn_clr_i || rd_data_i || rd_stat_i) |=> $stable(line_q)); // R7

endmodule

// File: tb/kcs_irq_combiner_tb_top.sv
module kcs_irq_combiner_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic obf_set_i = 0, atn_set_i = 0, atn_clr_i = 0, atn_irq_req_i = 0;
  logic rd_data_i = 0, rd_stat_i = 0, use_irq_i = 0, irq_en_i = 0;
  logic irq_o, atn_stat_o;

  always #10 clk = ~clk;

  kcs_irq_combiner dut_i (
    .clk(clk), .rst_n(rst_n), .obf_set_i(obf_set_i), .atn_set_i(atn_set_i),
    .atn_clr_i(atn_clr_i), .atn_irq_req_i(atn_irq_req_i), .rd_data_i(rd_data_i),
    .rd_stat_i(rd_stat_i), .use_irq_i(use_irq_i), .irq_en_i(irq_en_i),
    .irq_o(irq_o), .atn_stat_o(atn_stat_o)
  );

  // {obf_set, atn_set, atn_clr, atn_req, rd_data, rd_stat, use_irq, irq_en, exp_irq, exp_stat}
  localparam int NV = 25;
  localparam logic [9:0] VEC [NV] = '{
    10'b1000_0011_10, // R1 buffer-full raises
    10'b0101_0011_11, // R4 attention while buffer-full pending, no new raise
    10'b0000_1011_11, // R2 data read, attention holds line
    10'b0000_0111_01, // R3 status read lowers, status bit kept
    10'b0010_0011_00, // R5 clear status bit
    10'b0100_0011_01, // R4 set without request: status only
    10'b0010_0011_00, // R5
    10'b1000_0010_00, // R6 set while disabled
    10'b0000_0011_00, // R7 enable alone does not raise
    10'b1000_0011_00, // R10 already pending, no raise
    10'b0000_1010_00, // R2 clear while disabled
    10'b0101_0011_11, // R4 attention raises
    10'b0000_0010_11, // R7 disable alone does not lower
    10'b0010_0010_00, // R6 lowering not gated by enable
    10'b1000_0011_10, // R1
    10'b0101_0011_11, // R4 overlap
    10'b0000_0111_11, // R3 status read first, buffer-full holds
    10'b0000_1011_01, // R2 then data read lowers
    10'b0010_0011_00, // R5
    10'b1000_1011_00, // R8 set then read same cycle
    10'b1101_0011_11, // R8 attention then buffer-full same cycle
    10'b0111_0011_10, // R8 clear beats set
    10'b0000_1011_00, // R2
    10'b1000_0001_00, // R6 no configuration, no raise
    10'b0000_1011_00  // R2
  };

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [9:0] v);
    {obf_set_i, atn_set_i, atn_clr_i, atn_irq_req_i, rd_data_i, rd_stat_i,
     use_irq_i, irq_en_i} = v[9:2];
    @(negedge clk);
    {obf_set_i, atn_set_i, atn_clr_i, atn_irq_req_i, rd_data_i, rd_stat_i} = '0;
  endtask

  function automatic string tag_of(input int i);
    case (i)
      0, 14: return "R1";
      2, 10, 17, 22, 24: return "R2";
      3, 16: return "R3";
      1, 5, 11, 15: return "R4";
      4, 6, 18: return "R5";
      7, 13, 23: return "R6";
      8, 12: return "R7";
      9: return "R10";
      default: return "R8";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset irq", irq_o, 1'b0);
    chk("R9 reset stat", atn_stat_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      chk({tag_of(i), " irq"}, irq_o, VEC[i][1]);
      chk({tag_of(i), " stat"}, atn_stat_o, VEC[i][0]);
    end
    drive(10'b1101_0011_11);
    chk("R1 prep", irq_o, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 mid reset irq", irq_o, 1'b0);
    chk("R9 mid reset stat", atn_stat_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    drive(10'b1000_0011_10);
    chk("R9 pending cleared by reset", irq_o, 1'b1);
    drive(10'b0000_0111_00);
    chk("R3 read with attention idle keeps line", irq_o, 1'b1);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule